// File: doc/BRIEF.md
# Sequential Binary32 Square Root

This unit takes one IEEE 754 single-precision operand and returns its square root, correctly rounded under one of five rounding directions. A one-cycle `start` pulse captures the operand and the rounding selection. After a fixed number of clocks a one-cycle `done` pulse marks a valid result and its exception flags. The result and flags then stay unchanged until the next `done`.

Inside, the operand is first sorted into zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A subnormal is normalised with a leading-zero count. The unbiased exponent is halved, and when it is odd the significand is doubled first. A radix-2 restoring recurrence then produces one root bit per clock: 24 significand bits plus a guard bit. The final partial remainder acts as the sticky bit, and it drives both the rounding increment and the inexact flag. The result of a square root lies in a narrow exponent range, so the overflow, underflow and divide-by-zero flags are present on the ports but stay low.

Top module: `fsqrt_unit`

## Requirements
- R1: A positive normal or subnormal operand yields the correctly rounded square root. The result has sign bit 0, and its exponent field is never zero, so the result is never subnormal.
- R2: `rnd_mode` is read on the start cycle, and its lowest set bit selects the direction. Bit 0 is nearest with ties to even, bit 1 is nearest with ties away, bit 2 is toward +inf, bit 3 is toward -inf and bit 4 is toward zero. An all-zero value means toward zero. Because the result is positive, toward +inf increments whenever the result is inexact, and toward -inf and toward zero truncate.
- R3: For a normal positive operand with unbiased exponent e, the unbiased result exponent is floor(e/2) or floor(e/2)+1. Under toward-zero it is exactly floor(e/2).
- R4: `flag_inexact` is 1 exactly when the rounded result differs from the true root. It is 0 for perfect squares such as 4.0.
- R5: A negative operand that is nonzero and not a NaN returns the quiet NaN 0x7FC00000 and raises `flag_invalid`. This includes -inf and negative subnormals.
- R6: A signalling NaN (exponent all ones, fraction nonzero, fraction MSB 0) returns 0x7FC00000 with `flag_invalid`. A quiet NaN (fraction MSB 1) of either sign returns 0x7FC00000 with no flag.
- R7: +0 and -0 return themselves and +inf returns +inf, all with no flags raised.
- R8: `flag_divzero`, `flag_overflow` and `flag_underflow` are never 1.
- R9: `done` is a single-cycle pulse. It is first seen 26 rising edges after the edge that samples `start`. `result` and the flags change only together with `done`, and are held in between.
- R10: A `start` that arrives while `busy` is 1 is ignored. It does not alter the result in flight and produces no extra `done`.
- R11: After reset, `busy`, `done`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture operand and rounding selection when idle |
| operand | input | 32 | Binary32 operand |
| rnd_mode | input | 5 | One-hot rounding selection, lowest set bit wins |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle pulse: result and flags are valid |
| result | output | 32 | Binary32 square root, held until the next done |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_divzero | output | 1 | Divide-by-zero flag, constant low |
| flag_overflow | output | 1 | Overflow flag, constant low |
| flag_underflow | output | 1 | Underflow flag, constant low |
| flag_inexact | output | 1 | Inexact flag |

## Verification
Every operand class has the same latency. The edge that samples `start` counts as edge 0, edges 1 to 25 each add one root bit, and edge 26 registers the rounded result together with `done`. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. It requires `done` to be low after edges 1 to 25 and high after edge 26, and it compares result and flags at that same sample. One more falling edge later it checks that the pulse has dropped and that the result has not moved. For the busy case, `start` is raised during edge 6 and again during edge 26. The bench then expects the first operand's answer and no further `done` within the following window.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_SUB,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } op_class_e;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN,
        RM_NEAR_AWAY,
        RM_UP,
        RM_DOWN,
        RM_ZERO
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_ROUND
    } seq_state_e;

    // lowest set bit selects the direction; nothing set means toward zero
    function automatic rmode_e pick_mode(input logic [4:0] sel);
        if (sel[0])      return RM_NEAR_EVEN;
        else if (sel[1]) return RM_NEAR_AWAY;
        else if (sel[2]) return RM_UP;
        else if (sel[3]) return RM_DOWN;
        else             return RM_ZERO;
    endfunction

endpackage

// File: rtl/fsqrt_prep.sv
module fsqrt_prep
    import fsqrt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]  operand,
    output op_class_e              cls,
    output logic                   sgn,
    output logic [FRAC_W+1:0]      radicand,
    output logic signed [EXP_W+1:0] half_exp
);
    localparam int SW   = FRAC_W + 1;
    localparam int EW2  = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int LZW  = $clog2(FRAC_W + 1);

    logic [EXP_W-1:0]     exp_f;
    logic [FRAC_W-1:0]    frac;
    logic [LZW-1:0]       shift;
    logic [SW-1:0]        sig;
    logic signed [EW2-1:0] unb;

    assign sgn   = operand[EXP_W+FRAC_W];
    assign exp_f = operand[EXP_W+FRAC_W-1:FRAC_W];
    assign frac  = operand[FRAC_W-1:0];

    // distance that brings the highest set fraction bit up to the hidden position
    always_comb begin
        shift = '0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (frac[i]) shift = LZW'(FRAC_W - i);
        end
    end

    always_comb begin
        if (exp_f == '1)      cls = (frac == '0) ? CL_INF : (frac[FRAC_W-1] ? CL_QNAN : CL_SNAN);
        else if (exp_f == '0) cls = (frac == '0) ? CL_ZERO : CL_SUB;
        else                  cls = CL_NORM;
    end

    always_comb begin
        if (exp_f == '0) begin
            sig = SW'({1'b0, frac} << shift);
            unb = $signed(EW2'(1 - BIAS)) - $signed(EW2'(shift));
        end else begin
            sig = {1'b1, frac};
            unb = $signed({2'b00, exp_f}) - $signed(EW2'(BIAS));
        end
    end

    // odd exponent: double the significand so the halving is exact
    assign radicand = unb[0] ? {sig, 1'b0} : {1'b0, sig};
    assign half_exp = unb >>> 1;

endmodule

// File: rtl/fsqrt_step.sv
module fsqrt_step #(
    parameter int QW = 25,
    parameter int RW = QW + 1
) (
    input  logic [RW-1:0] rem_i,
    input  logic [QW-1:0] root_i,
    input  logic [1:0]    pair_i,
    output logic [RW-1:0] rem_o,
    output logic [QW-1:0] root_o
);
    logic [RW+1:0] widened;
    logic [RW+1:0] trial;
    logic [RW+1:0] diff;
    logic [RW+1:0] chosen;
    logic          fits;
    logic          unused_top;

    assign widened = {rem_i, pair_i};
    assign trial   = (RW+2)'({root_i, 2'b01});
    assign fits    = widened >= trial;
    assign diff    = widened - trial;
    assign chosen  = fits ? diff : widened;
    assign rem_o   = chosen[RW-1:0];
    assign root_o  = {root_i[QW-2:0], fits};
    assign unused_top = ^chosen[RW+1:RW] ^ root_i[QW-1];

endmodule

// File: rtl/fsqrt_round.sv
module fsqrt_round
    import fsqrt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  op_class_e               cls,
    input  logic                    sgn,
    input  logic signed [EXP_W+1:0] half_exp,
    input  logic [FRAC_W+1:0]       root,
    input  logic                    rem_nz,
    input  rmode_e                  rm,
    output logic [EXP_W+FRAC_W:0]   res,
    output logic                    nv,
    output logic                    nx
);
    localparam int EW2  = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W+FRAC_W:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [EXP_W+FRAC_W:0] PINF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [FRAC_W:0]   mant;
    logic              guard;
    logic              bump;
    logic [FRAC_W+1:0] sum;
    logic [EW2-1:0]    ebias;
    logic              unused_ehi;

    assign mant  = root[FRAC_W+1:1];
    assign guard = root[0];

    always_comb begin
        case (rm)
            RM_NEAR_EVEN: bump = guard & (rem_nz | mant[0]);
            RM_NEAR_AWAY: bump = guard;
            RM_UP:        bump = guard | rem_nz;
            default:      bump = 1'b0;
        endcase
    end

    assign sum   = {1'b0, mant} + (FRAC_W+2)'(bump);
    assign ebias = EW2'(half_exp) + EW2'(BIAS) + EW2'(sum[FRAC_W+1]);
    assign unused_ehi = ^ebias[EW2-1:EXP_W];

    always_comb begin
        res = QNAN;
        nv  = 1'b0;
        nx  = 1'b0;
        case (cls)
            CL_QNAN: res = QNAN;
            CL_SNAN: nv  = 1'b1;
            CL_ZERO: res = {sgn, {(EXP_W+FRAC_W){1'b0}}};
            CL_INF: begin
                if (sgn) nv  = 1'b1;
                else     res = PINF;
            end
            default: begin
                if (sgn) begin
                    nv = 1'b1;
                end else begin
                    res = {1'b0, ebias[EXP_W-1:0], sum[FRAC_W-1:0]};
                    nx  = guard | rem_nz;
                end
            end
        endcase
    end

endmodule

// File: rtl/fsqrt_unit.sv
module fsqrt_unit
    import fsqrt_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [EXP_W+FRAC_W:0]   operand,
    input  logic [4:0]              rnd_mode,
    output logic                    busy,
    output logic                    done,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic                    flag_invalid,
    output logic                    flag_divzero,
    output logic                    flag_overflow,
    output logic                    flag_underflow,
    output logic                    flag_inexact
);
    localparam int W    = EXP_W + FRAC_W + 1;
    localparam int EW2  = EXP_W + 2;
    localparam int QW   = FRAC_W + 2;
    localparam int RW   = QW + 1;
    localparam int XW   = 2 * QW;
    localparam int CW   = $clog2(QW + 1);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic [XW-1:0]  rad;
        logic [RW-1:0]  rem;
        logic [QW-1:0]  root;
        op_class_e      cls;
        logic           sgn;
        logic [EW2-1:0] hexp;
        rmode_e         rm;
        logic           done;
        logic [W-1:0]   res;
        logic           nv;
        logic           nx;
    } regs_t;

    regs_t q, d;

    op_class_e             prep_cls;
    logic                  prep_sgn;
    logic [QW-1:0]         prep_rad;
    logic signed [EW2-1:0] prep_hexp;
    logic [RW-1:0]         step_rem;
    logic [QW-1:0]         step_root;
    logic [W-1:0]          rnd_res;
    logic                  rnd_nv;
    logic                  rnd_nx;

    fsqrt_prep #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prep (
        .operand  (operand),
        .cls      (prep_cls),
        .sgn      (prep_sgn),
        .radicand (prep_rad),
        .half_exp (prep_hexp)
    );

    fsqrt_step #(.QW(QW), .RW(RW)) u_step (
        .rem_i  (q.rem),
        .root_i (q.root),
        .pair_i (q.rad[XW-1:XW-2]),
        .rem_o  (step_rem),
        .root_o (step_root)
    );

    fsqrt_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .cls      (q.cls),
        .sgn      (q.sgn),
        .half_exp ($signed(q.hexp)),
        .root     (q.root),
        .rem_nz   (|q.rem),
        .rm       (q.rm),
        .res      (rnd_res),
        .nv       (rnd_nv),
        .nx       (rnd_nx)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_ITER;
                    d.cnt  = CW'(QW);
                    d.rad  = {prep_rad, {QW{1'b0}}};
                    d.rem  = '0;
                    d.root = '0;
                    d.cls  = prep_cls;
                    d.sgn  = prep_sgn;
                    d.hexp = prep_hexp;
                    d.rm   = pick_mode(rnd_mode);
                end
            end
            ST_ITER: begin
                d.rem  = step_rem;
                d.root = step_root;
                d.rad  = {q.rad[XW-3:0], 2'b00};
                d.cnt  = q.cnt - CW'(1);
                if (q.cnt == CW'(1)) d.st = ST_ROUND;
            end
            ST_ROUND: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                d.res  = rnd_res;
                d.nv   = rnd_nv;
                d.nx   = rnd_nx;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy           = (q.st != ST_IDLE);
    assign done           = q.done;
    assign result         = q.res;
    assign flag_invalid   = q.nv;
    assign flag_inexact   = q.nx;
    assign flag_divzero   = 1'b0;
    assign flag_overflow  = 1'b0;
    assign flag_underflow = 1'b0;

    logic signed [EW2-1:0] res_unb;
    assign res_unb = $signed({2'b00, rnd_res[W-2:FRAC_W]}) - $signed(EW2'(BIAS));

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESULT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R9
    AST_NO_SUBNORMAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[W-2:FRAC_W] == '0) |-> (result[FRAC_W-1:0] == '0)); // R1
    AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_invalid) |-> (result == QNAN && !flag_inexact)); // R5
    AST_EXP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ROUND && q.cls == CL_NORM && !q.sgn)
        |-> (res_unb == $signed(q.hexp) || res_unb == $signed(q.hexp) + 1)); // R3
    AST_EXP_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ROUND && q.cls == CL_NORM && !q.sgn && q.rm == RM_ZERO)
        |-> (res_unb == $signed(q.hexp))); // R3
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> ($stable(q.hexp) && $stable(q.cls) && $stable(q.sgn))); // R10

endmodule

// File: tb/fsqrt_unit_test.sv
module fsqrt_unit_test;
    localparam int LAT = 26;
    localparam logic [31:0] QNAN = 32'h7fc00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [4:0]  rnd_mode = '0;
    logic        busy, done, flag_invalid, flag_divzero, flag_overflow, flag_underflow, flag_inexact;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    fsqrt_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .rnd_mode(rnd_mode),
        .busy(busy), .done(done), .result(result), .flag_invalid(flag_invalid),
        .flag_divzero(flag_divzero), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd32();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [127:0] isqrt(input logic [127:0] n);
        logic [127:0] lo, hi, mid;
        lo = '0;
        hi = 128'd1 << 54;
        while (hi - lo > 1) begin
            mid = (lo + hi) >> 1;
            if (mid * mid <= n) lo = mid;
            else                hi = mid;
        end
        return lo;
    endfunction

    // reference value from the requirements: exact integer root plus rounding rules
    task automatic model(input logic [31:0] op, input logic [4:0] rm,
                         output logic [31:0] r, output logic nv, output logic nx);
        logic [7:0] ex;
        logic [22:0] fr;
        logic [127:0] m, n, rt, low;
        logic [24:0] mt;
        logic g, st, up;
        int k, p, ue, md;
        ex = op[30:23];
        fr = op[22:0];
        nv = 1'b0;
        nx = 1'b0;
        r  = QNAN;
        md = rm[0] ? 0 : rm[1] ? 1 : rm[2] ? 2 : rm[3] ? 3 : 4;
        if (ex == 8'hff && fr != 0) begin
            nv = !fr[22];
        end else if (ex == 0 && fr == 0) begin
            r = op;
        end else if (op[31]) begin
            nv = 1'b1;
        end else if (ex == 8'hff) begin
            r = op;
        end else begin
            if (ex == 0) begin m = 128'(fr); k = -149; end
            else begin m = 128'({1'b1, fr}); k = int'(ex) - 150; end
            if ((k % 2) != 0) begin m = m << 1; k = k - 1; end
            n  = m << 80;
            rt = isqrt(n);
            p  = 0;
            for (int i = 0; i < 128; i++) if (rt[i]) p = i;
            mt  = 25'(rt >> (p - 23));
            g   = rt[p-24];
            low = rt & ((128'd1 << (p - 24)) - 1);
            st  = (low != 0) || (rt * rt != n);
            up  = (md == 0) ? (g & (st | mt[0])) : (md == 1) ? g : (md == 2) ? (g | st) : 1'b0;
            ue  = p - 40 + k / 2;
            mt  = mt + 25'(up);
            if (mt[24]) begin mt = mt >> 1; ue++; end
            nx = g | st;
            r  = {1'b0, 8'(ue + 127), mt[22:0]};
        end
    endtask

    task automatic run_op(input logic [31:0] op, input logic [4:0] rm, input bit poke);
        logic [31:0] er;
        logic env, enx;
        bit timing_ok;
        int ue_in, eh, got;
        model(op, rm, er, env, enx);
        timing_ok = 1'b1;
        @(negedge clk);
        start = 1'b1; operand = op; rnd_mode = rm;
        @(negedge clk);
        start = 1'b0; operand = ~op; rnd_mode = ~rm;
        for (int i = 1; i <= LAT; i++) begin
            @(negedge clk);
            if (done !== (i == LAT)) timing_ok = 1'b0;
            start = 1'b0;
            if (poke && (i == 5 || i == LAT - 1)) begin
                start = 1'b1; operand = 32'h4e00_0000; rnd_mode = 5'b00100;
            end
        end
        start = 1'b0;
        chk(timing_ok, "R9 done after 26 edges", 64'(done), 64'(1));
        chk(result === er, poke ? "R10 result with ignored start" : "R1/R2/R5/R6/R7 result",
            {32'(op), result}, {32'(op), er});
        chk(flag_invalid === env, "R5/R6 invalid flag", 64'(flag_invalid), 64'(env));
        chk(flag_inexact === enx, "R4 inexact flag", 64'(flag_inexact), 64'(enx));
        chk({flag_divzero, flag_overflow, flag_underflow} === 3'b000, "R8 quiet flags",
            64'({flag_divzero, flag_overflow, flag_underflow}), 64'(0));
        if (!op[31] && op[30:23] != 8'h00 && op[30:23] != 8'hff) begin
            ue_in = int'(op[30:23]) - 127;
            eh    = ue_in >>> 1;
            got   = int'(result[30:23]) - 127;
            chk((got == eh || got == eh + 1) && (rm != 5'b10000 || got == eh),
                "R3 exponent window", 64'(got), 64'(eh));
        end
        @(negedge clk);
        chk(!done && result === er, "R9 pulse drops and result held", {63'(0), done}, 64'(0));
        if (poke) begin
            bit extra;
            extra = 1'b0;
            for (int i = 0; i < LAT + 4; i++) begin
                @(negedge clk);
                if (done) extra = 1'b1;
            end
            chk(!extra && result === er, "R10 no second done", 64'(extra), 64'(0));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [4:0] modes [5];
        modes[0] = 5'b00001; modes[1] = 5'b00010; modes[2] = 5'b00100;
        modes[3] = 5'b01000; modes[4] = 5'b10000;
        repeat (3) @(negedge clk);
        chk({busy, done, flag_invalid, flag_inexact, flag_overflow} == 5'b0 && result == 0,
            "R11 reset state", {27'(0), busy, done, flag_invalid, flag_inexact, flag_overflow}, 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // perfect squares and simple values in every direction (R2, R4)
        for (int mi = 0; mi < 5; mi++) begin
            run_op(32'h4080_0000, modes[mi], 1'b0);
            run_op(32'h3f80_0000, modes[mi], 1'b0);
            run_op(32'h4000_0000, modes[mi], 1'b0);
            run_op(32'h4040_0000, modes[mi], 1'b0);
            run_op(32'h0000_0001, modes[mi], 1'b0);
            run_op(32'h7f7f_ffff, modes[mi], 1'b0);
        end
        // R2: lowest set bit wins, empty selection truncates
        run_op(32'h4040_0000, 5'b00000, 1'b0);
        run_op(32'h4040_0000, 5'b10110, 1'b0);
        run_op(32'h4120_0000, 5'b11100, 1'b0);

        // R5, R6, R7 specials
        run_op(32'h0000_0000, 5'b00001, 1'b0);
        run_op(32'h8000_0000, 5'b00100, 1'b0);
        run_op(32'h7f80_0000, 5'b00001, 1'b0);
        run_op(32'hff80_0000, 5'b00001, 1'b0);
        run_op(32'hbf80_0000, 5'b01000, 1'b0);
        run_op(32'h8000_0003, 5'b00001, 1'b0);
        run_op(32'h7fc0_0000, 5'b00001, 1'b0);
        run_op(32'h7fc1_2345, 5'b00010, 1'b0);
        run_op(32'hffc0_0000, 5'b00001, 1'b0);
        run_op(32'h7f80_0001, 5'b00001, 1'b0);
        run_op(32'hff9f_ffff, 5'b10000, 1'b0);

        // R1, R3: every normal exponent with a random fraction
        for (int e = 1; e < 255; e++) begin
            v = rnd32();
            run_op({1'b0, 8'(e), v[22:0]}, modes[e % 5], 1'b0);
        end
        // R1: subnormals at every leading-zero count
        for (int s = 0; s < 23; s++) begin
            for (int mi = 0; mi < 5; mi += 2) begin
                v = rnd32();
                run_op({9'b0, (23'h40_0000 >> s) | (v[22:0] >> (s + 1))}, modes[mi], 1'b0);
            end
        end
        // random positive normals in all directions
        for (int t = 0; t < 40; t++) begin
            v = rnd32();
            if (v[30:23] == 8'hff || v[30:23] == 8'h00) v[30:23] = 8'h7e;
            for (int mi = 0; mi < 5; mi++) run_op({1'b0, v[30:0]}, modes[mi], 1'b0);
        end
        // R10: start while busy
        run_op(32'h4049_0fdb, 5'b00001, 1'b1);
        run_op(32'h0012_3456, 5'b00100, 1'b1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule